// File: doc/BRIEF.md
# Indexed UART Control Register Bank

This block holds the extended control registers of a 16550-style UART. Software reaches them indirectly through the usual eight-location host register window. It first writes an index byte to host address 3'b111, the scratchpad location. It then writes or reads the selected control location at host address 3'b101. The block decodes its stored contents and drives them to the rest of the UART: the additional control byte, the clock prescaler split into integer and fractional parts, the N-times sampling select, the clock-source byte, the transmit and receive trigger levels, and the two flow-control thresholds.

Reads of address 3'b101 return the indexed location only while the read-enable bit (bit 6) of the additional control register is set. That register lives at index 0x00, so software must set the bit there first, then move the index to the location it wants to read. When the bit is clear, the standard register value from outside the block passes through unchanged. A line-control write of 0xBF locks the indexed path. The lock lasts until a line-control write of any other value. A write of 0x00 to index 0x0C soft-resets the UART and leaves the clock-source byte as it was.

Top module: `uart_xreg_bank`

## Requirements
- R1: While unlocked, a host write to address 3'b111 loads the index register. Host writes to address 3'b111 are always also passed to the standard registers (`std_wr_en` high).
- R2: A host write to address 3'b011 (line control) of 0xBF sets the lock. A write there of any other value clears it. While locked, writes to 3'b101 and 3'b111 change no bank register and no index, and `std_wr_en` is high for them. Reads of 3'b101 return `std_rdata`.
- R3: While unlocked and bit 6 of the index-0x00 register is 1, a read of address 3'b101 returns the indexed value. Otherwise every read returns `std_rdata`. Reads of address 3'b111 always return `std_rdata`.
- R4: While unlocked, a write to 3'b101 updates the indexed register whatever the value of the read-enable bit, and `std_wr_en` is low for that write.
- R5: Indices 0x04, 0x05, 0x06 and 0x07 hold 7-bit levels (transmit trigger, receive trigger, flow low, flow high) in bits [6:0]. Bit 7 is discarded on write and reads as 0.
- R6: Index 0x01 outputs bits [7:3] as the integer prescaler and bits [2:0] as the fractional prescaler. Index 0x02 keeps only bits [3:0] as the N-times select, and its bits [7:4] read as 0. Indices 0x00 and 0x03 are full 8-bit registers.
- R7: Indices 0x08, 0x09, 0x0A and 0x0B read 0x16, 0xC9, 0x50 and 0x01. Writes to them change nothing.
- R8: A write of 0x00 to index 0x0C clears every writable register except index 0x03. It also clears the index and the lock, and raises `soft_rst` for exactly the following cycle. A nonzero write there has no effect. Index 0x0C reads 0x00.
- R9: Index 0x0F reads `stat_a` and index 0x10 reads `stat_b`. Every other index reads 0x00, and writes to it are ignored.
- R10: Hardware reset clears all writable registers, index 0x03 included, as well as the index, the lock and `soft_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| std_rdata | input | 8 | Read value of the standard register at host_addr |
| stat_a | input | 8 | Status byte shown at index 0x0F |
| stat_b | input | 8 | Status byte shown at index 0x10 |
| host_rdata | output | 8 | Host read data |
| std_wr_en | output | 1 | Write strobe passed to the standard registers |
| soft_rst | output | 1 | One-cycle soft-reset pulse to the UART |
| acr_q | output | 8 | Additional control register contents |
| pre_int | output | 5 | Prescaler integer part |
| pre_frac | output | 3 | Prescaler fractional part |
| nclk_sel | output | 4 | N-times sampling select |
| cks_q | output | 8 | Clock-source select byte |
| tx_trig | output | 7 | Transmit interrupt trigger level |
| rx_trig | output | 7 | Receive interrupt trigger level |
| fc_lo | output | 7 | Flow-control low threshold |
| fc_hi | output | 7 | Flow-control high threshold |

## Verification
The hardest states to reach are the combined ones. One is the lock set while an index and the read-enable bit are already programmed. Another is a soft reset issued while the clock-source byte holds a nonzero value. The stimulus first programs every register and reads each back through the enable-bit sequence. It then sets the lock and writes to both indexed addresses, and unlocks to show that neither write took effect. Last, it sets the clock-source byte before the soft-reset write, so that the reset's selective clearing and its one-cycle pulse can both be seen at the ports.

// File: rtl/uart_xreg_bank.sv
module uart_xreg_bank #(
  parameter logic [7:0] LOCK_CODE = 8'hBF,
  parameter logic [7:0] ID0 = 8'h16,
  parameter logic [7:0] ID1 = 8'hC9,
  parameter logic [7:0] ID2 = 8'h50,
  parameter logic [7:0] REVB = 8'h01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] host_addr,
  input  logic [7:0] host_wdata,
  input  logic       host_wr,
  input  logic [7:0] std_rdata,
  input  logic [7:0] stat_a,
  input  logic [7:0] stat_b,
  output logic [7:0] host_rdata,
  output logic       std_wr_en,
  output logic       soft_rst,
  output logic [7:0] acr_q,
  output logic [4:0] pre_int,
  output logic [2:0] pre_frac,
  output logic [3:0] nclk_sel,
  output logic [7:0] cks_q,
  output logic [6:0] tx_trig,
  output logic [6:0] rx_trig,
  output logic [6:0] fc_lo,
  output logic [6:0] fc_hi
);
  localparam logic [2:0] A_LCR  = 3'd3;
  localparam logic [2:0] A_DATA = 3'd5;
  localparam logic [2:0] A_IDX  = 3'd7;
  localparam int RDEN_BIT = 6;

  logic [7:0] idx;
  logic       lock;
  logic [7:0] cpr;
  logic [7:0] xval;

  wire bank_wr = host_wr && host_addr == A_DATA && !lock;
  wire idx_wr  = host_wr && host_addr == A_IDX && !lock;
  wire sr_hit  = bank_wr && idx == 8'h0C && host_wdata == 8'h00;

  assign std_wr_en = host_wr && !bank_wr;
  assign pre_int   = cpr[7:3];
  assign pre_frac  = cpr[2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0; lock <= 1'b0; soft_rst <= 1'b0;
      acr_q <= '0; cpr <= '0; nclk_sel <= '0;
      tx_trig <= '0; rx_trig <= '0; fc_lo <= '0; fc_hi <= '0;
    end else begin
      soft_rst <= sr_hit;
      if (sr_hit) begin
        idx <= '0; lock <= 1'b0;
        acr_q <= '0; cpr <= '0; nclk_sel <= '0;
        tx_trig <= '0; rx_trig <= '0; fc_lo <= '0; fc_hi <= '0;
      end else begin
        if (host_wr && host_addr == A_LCR) lock <= (host_wdata == LOCK_CODE);
        if (idx_wr) idx <= host_wdata;
        if (bank_wr) begin
          case (idx)
            8'h00: acr_q    <= host_wdata;
            8'h01: cpr      <= host_wdata;
            8'h02: nclk_sel <= host_wdata[3:0];
            8'h04: tx_trig  <= host_wdata[6:0];
            8'h05: rx_trig  <= host_wdata[6:0];
            8'h06: fc_lo    <= host_wdata[6:0];
            8'h07: fc_hi    <= host_wdata[6:0];
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cks_q <= '0;
    else if (bank_wr && idx == 8'h03) cks_q <= host_wdata;
  end

  always_comb begin
    case (idx)
      8'h00: xval = acr_q;
      8'h01: xval = cpr;
      8'h02: xval = {4'h0, nclk_sel};
      8'h03: xval = cks_q;
      8'h04: xval = {1'b0, tx_trig};
      8'h05: xval = {1'b0, rx_trig};
      8'h06: xval = {1'b0, fc_lo};
      8'h07: xval = {1'b0, fc_hi};
      8'h08: xval = ID0;
      8'h09: xval = ID1;
      8'h0A: xval = ID2;
      8'h0B: xval = REVB;
      8'h0F: xval = stat_a;
      8'h10: xval = stat_b;
      default: xval = 8'h00;
    endcase
  end

  assign host_rdata = (host_addr == A_DATA && !lock && acr_q[RDEN_BIT]) ? xval : std_rdata;

  AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == A_IDX && !lock) |=> idx == $past(host_wdata)); // R1

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == A_DATA && lock) |=>
      $stable({acr_q, cpr, nclk_sel, cks_q, tx_trig, rx_trig, fc_lo, fc_hi})); // R2

  AST_LOCK_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> host_rdata == std_rdata); // R2

  AST_LEVEL_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == A_DATA && !lock && acr_q[RDEN_BIT] && idx >= 8'h04 && idx <= 8'h07)
      |-> !host_rdata[7]); // R5

  AST_SRST_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == A_DATA && !lock && idx == 8'h0C && host_wdata == 8'h00)
      |=> (soft_rst && cks_q == $past(cks_q) && acr_q == 8'h00 && idx == 8'h00)); // R8

  AST_SRST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !soft_rst); // R8
endmodule

// File: tb/uart_xreg_bank_tb_top.sv
module uart_xreg_bank_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic       host_wr = 1'b0;
  logic [7:0] std_rdata = 8'hA5;
  logic [7:0] stat_a = 8'h3C;
  logic [7:0] stat_b = 8'hE1;
  logic [7:0] host_rdata;
  logic       std_wr_en, soft_rst;
  logic [7:0] acr_q, cks_q;
  logic [4:0] pre_int;
  logic [2:0] pre_frac;
  logic [3:0] nclk_sel;
  logic [6:0] tx_trig, rx_trig, fc_lo, fc_hi;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uart_xreg_bank dut_i (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .std_rdata(std_rdata), .stat_a(stat_a), .stat_b(stat_b),
    .host_rdata(host_rdata), .std_wr_en(std_wr_en), .soft_rst(soft_rst),
    .acr_q(acr_q), .pre_int(pre_int), .pre_frac(pre_frac), .nclk_sel(nclk_sel),
    .cks_q(cks_q), .tx_trig(tx_trig), .rx_trig(rx_trig), .fc_lo(fc_lo), .fc_hi(fc_hi)
  );

  // {op, addr, data, expected}: op 0 = write, op 1 = read and compare
  localparam int NV = 52;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0,3'd7,8'h00,8'h00}, {1'b0,3'd5,8'h40,8'h00}, {1'b1,3'd5,8'h00,8'h40},
    {1'b0,3'd7,8'h01,8'h00}, {1'b0,3'd5,8'hAB,8'h00}, {1'b1,3'd5,8'h00,8'hAB},
    {1'b0,3'd7,8'h02,8'h00}, {1'b0,3'd5,8'hFF,8'h00}, {1'b1,3'd5,8'h00,8'h0F},
    {1'b0,3'd7,8'h03,8'h00}, {1'b0,3'd5,8'h5A,8'h00}, {1'b1,3'd5,8'h00,8'h5A},
    {1'b0,3'd7,8'h04,8'h00}, {1'b0,3'd5,8'hFF,8'h00}, {1'b1,3'd5,8'h00,8'h7F},
    {1'b0,3'd7,8'h05,8'h00}, {1'b0,3'd5,8'h81,8'h00}, {1'b1,3'd5,8'h00,8'h01},
    {1'b0,3'd7,8'h06,8'h00}, {1'b0,3'd5,8'h33,8'h00}, {1'b1,3'd5,8'h00,8'h33},
    {1'b0,3'd7,8'h07,8'h00}, {1'b0,3'd5,8'hC0,8'h00}, {1'b1,3'd5,8'h00,8'h40},
    {1'b0,3'd7,8'h08,8'h00}, {1'b0,3'd5,8'h00,8'h00}, {1'b1,3'd5,8'h00,8'h16},
    {1'b0,3'd7,8'h09,8'h00}, {1'b1,3'd5,8'h00,8'hC9},
    {1'b0,3'd7,8'h0A,8'h00}, {1'b1,3'd5,8'h00,8'h50},
    {1'b0,3'd7,8'h0B,8'h00}, {1'b1,3'd5,8'h00,8'h01},
    {1'b0,3'd7,8'h0C,8'h00}, {1'b0,3'd5,8'h55,8'h00}, {1'b1,3'd5,8'h00,8'h00},
    {1'b0,3'd7,8'h0F,8'h00}, {1'b1,3'd5,8'h00,8'h3C},
    {1'b0,3'd7,8'h10,8'h00}, {1'b1,3'd5,8'h00,8'hE1},
    {1'b0,3'd7,8'h20,8'h00}, {1'b0,3'd5,8'h77,8'h00}, {1'b1,3'd5,8'h00,8'h00},
    {1'b1,3'd7,8'h00,8'hA5},
    {1'b0,3'd7,8'h00,8'h00}, {1'b0,3'd5,8'h00,8'h00}, {1'b1,3'd5,8'h00,8'hA5},
    {1'b0,3'd7,8'h01,8'h00}, {1'b0,3'd5,8'h12,8'h00},
    {1'b0,3'd7,8'h00,8'h00}, {1'b0,3'd5,8'h40,8'h00},
    {1'b0,3'd7,8'h01,8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk);
    host_addr = a; host_wr = 1'b0;
    #1 check(req, host_rdata, exp);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: hardware reset state
    check("R10 acr", acr_q, 8'h00);
    check("R10 soft_rst", {7'd0, soft_rst}, 8'h00);
    rst_n = 1'b1;
    // R3: read enable clear after reset -> standard path
    rd("R3 rden clear", 3'd5, 8'hA5);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][19]) rd("R1 R3 R5 R6 R7 R9 vector", VEC[i][18:16], VEC[i][7:0]);
      else wr(VEC[i][18:16], VEC[i][15:8]);
    end
    // R4: value written with read enable clear is visible now
    rd("R4 write without rden", 3'd5, 8'h12);
    check("R6 pre_int", {3'd0, pre_int}, 8'h02);
    check("R6 pre_frac", {5'd0, pre_frac}, 8'h02);
    check("R5 tx_trig", {1'b0, tx_trig}, 8'h7F);
    check("R5 fc_hi", {1'b0, fc_hi}, 8'h40);

    // R4 / R1: std_wr_en routing
    @(negedge clk);
    host_addr = 3'd5; host_wdata = 8'h12; host_wr = 1'b1;
    #1 check("R4 std_wr_en low", {7'd0, std_wr_en}, 8'h00);
    host_addr = 3'd7; host_wdata = 8'h01;
    #1 check("R1 std_wr_en high", {7'd0, std_wr_en}, 8'h01);
    @(negedge clk); host_wr = 1'b0;

    // R2: lockout
    wr(3'd3, 8'hBF);
    rd("R2 locked read", 3'd5, 8'hA5);
    @(negedge clk);
    host_addr = 3'd5; host_wdata = 8'h99; host_wr = 1'b1;
    #1 check("R2 std_wr_en locked", {7'd0, std_wr_en}, 8'h01);
    @(negedge clk); host_wr = 1'b0;
    wr(3'd7, 8'h02);
    check("R2 prescaler kept", {pre_int, pre_frac}, 8'h12);
    wr(3'd3, 8'h03);
    rd("R2 index kept after unlock", 3'd5, 8'h12);

    // R8: soft reset keeps clock-source byte
    wr(3'd7, 8'h0C);
    @(negedge clk);
    host_addr = 3'd5; host_wdata = 8'h00; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    check("R8 pulse", {7'd0, soft_rst}, 8'h01);
    check("R8 cks kept", cks_q, 8'h5A);
    check("R8 acr cleared", acr_q, 8'h00);
    check("R8 rx_trig cleared", {1'b0, rx_trig}, 8'h00);
    @(negedge clk);
    check("R8 pulse one cycle", {7'd0, soft_rst}, 8'h00);
    wr(3'd5, 8'h40);
    rd("R8 index cleared", 3'd5, 8'h40);

    // R10: hardware reset also clears clock-source byte
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R10 cks cleared", cks_q, 8'h00);
    check("R10 acr cleared", acr_q, 8'h00);
    rst_n = 1'b1;

    done = 1'b1;
    finish_run();
  end
endmodule